// File: doc/BRIEF.md
# Addressed Serial Display-Frame Receiver

This block takes a three-wire serial link made of a chip-enable, a serial clock and a data line. It decodes frames sent to one fixed device address and keeps an 88-bit display image plus a small set of display control fields. All three serial lines are asynchronous to the system clock. The block passes them through two-flop synchronizers and then finds their edges in the system clock domain. A frame has two phases, which the chip-enable level tells apart. While chip-enable is low, an 8-bit address is shifted in, least-significant bit first. After chip-enable goes high, a 56-bit payload follows. Each data bit is taken on a rising edge of the serial clock.

When chip-enable falls, the frame is committed, but only if the address matched and exactly 56 payload bits arrived. The last payload bit is a direction flag. Direction 0 loads the lower 44 image bits together with the six control fields. Direction 1 loads only the upper 44 image bits. Any other frame is dropped and every held value stays as it was.

The image and control outputs are plain held levels that update once per committed frame. They are not a stream, so there is no valid/ready handshake and no back-pressure. The serial link has no flow control either. The sender only has to space its edges a few system clocks apart.

Top module: `lcd_frame_rx`

## Requirements
- R1: After reset, `disp_image` is all zeros, `port_mode`, `half_bias`, `seg_blank` and `pwr_save` are 0, and `ctl_empty` is 1.
- R2: The address is the last 8 data bits clocked while chip-enable is low, with the first bit sent as bit 0. A frame is accepted only when this value equals 0x44. A frame with any other address changes no output.
- R3: A direction-0 frame carries payload bit k (k = 0..43, in arrival order) to `disp_image[k]`. The direction flag is the 56th bit, arrival index 55.
- R4: A direction-0 frame sets the control fields from fixed arrival indices: 49 gives `port_mode[0]`, 50 gives `port_mode[1]`, 51 gives `port_mode[2]`, 52 gives `half_bias`, 53 gives `seg_blank` and 54 gives `pwr_save`. Arrival indices 44..48 are ignored.
- R5: A direction-1 frame carries payload bit k (k = 0..43) to `disp_image[44+k]`. It leaves `disp_image[43:0]` and all control fields unchanged.
- R6: Outputs change only when chip-enable falls. While a frame is still being shifted in, all outputs keep their previous values.
- R7: A frame whose payload bit count is not exactly 56 (for example 55 or 57) changes no output.
- R8: Frames are accepted the same way whether the serial clock rests low or rests high between bits and around the chip-enable edges.
- R9: `ctl_empty` falls to 0 on the first committed direction-0 frame and stays 0 until reset. Direction-1 frames do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_in | input | 1 | Serial chip-enable, asynchronous; low = address phase, high = payload phase |
| sck_in | input | 1 | Serial clock, asynchronous; data taken on its rising edge |
| sdi_in | input | 1 | Serial data, asynchronous |
| disp_image | output | 88 | Held display image; bits 43:0 from direction-0 frames, 87:44 from direction-1 frames |
| port_mode | output | 3 | Held output-port selection field |
| half_bias | output | 1 | Held drive-bias selection bit |
| seg_blank | output | 1 | Held all-segments-off request |
| pwr_save | output | 1 | Held power-save request |
| ctl_empty | output | 1 | High until a valid direction-0 frame has been committed |

## Verification
A wrong internal state cannot show at the ports until the next chip-enable fall, because every output is held between commits. A corrupted bit counter or address register shows up as a frame that is wrongly accepted or wrongly dropped. A misaligned payload shift register shows up as displaced image or control bits. Either effect appears at the ports three system clocks after chip-enable falls. For this reason the bench compares every output after each frame, and also just before chip-enable falls to catch early writes.

// File: rtl/lcd_frame_rx_pkg.sv
package lcd_frame_rx_pkg;
  // Control fields held from a direction-0 frame, LSB = first arrived field.
  typedef struct packed {
    logic       pwr_save;
    logic       seg_blank;
    logic       half_bias;
    logic [2:0] port_mode;
  } ctl_fields_t;

  localparam int CTL_FIELD_W = $bits(ctl_fields_t);
endpackage

// File: rtl/lcd_frame_rx_sync.sv
module lcd_frame_rx_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      logic meta_q, stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          stab_q <= 1'b0;
        end else begin
          meta_q <= async_in[gi];
          stab_q <= meta_q;
        end
      end
      assign sync_out[gi] = stab_q;
    end
  endgenerate
endmodule

// File: rtl/lcd_frame_rx_deframe.sv
module lcd_frame_rx_deframe #(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  DEV_ADDR = 8'h44,
  parameter int          PAY_W    = 56,
  parameter int          BANK_W   = 44,
  parameter int          CTL_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_lvl,
  input  logic              sck_lvl,
  input  logic              dat_lvl,
  output logic              commit,
  output logic              commit_dir,
  output logic [BANK_W-1:0] pay_bank,
  output logic [CTL_W-1:0]  pay_ctl
);
  localparam int CNT_W   = $clog2(PAY_W + 2);
  localparam int CNT_SAT = PAY_W + 1;
  localparam int CTL_LSB = PAY_W - 1 - CTL_W;

  logic              sel_q, sck_q;
  logic              sel_rise, sel_fall, sck_rise;
  logic [ADDR_W-1:0] addr_sr;
  logic [PAY_W-1:0]  pay_sr;
  logic [CNT_W-1:0]  bit_cnt;
  logic              addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      sel_q <= sel_lvl;
      sck_q <= sck_lvl;
    end
  end

  assign sel_rise = sel_lvl & ~sel_q;
  assign sel_fall = ~sel_lvl & sel_q;
  assign sck_rise = sck_lvl & ~sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_sr  <= '0;
      pay_sr   <= '0;
      bit_cnt  <= '0;
      addr_hit <= 1'b0;
    end else begin
      if (sck_rise && !sel_lvl)
        addr_sr <= {dat_lvl, addr_sr[ADDR_W-1:1]};
      if (sel_rise) begin
        addr_hit <= (addr_sr == DEV_ADDR[ADDR_W-1:0]);
        bit_cnt  <= '0;
      end else if (sel_fall) begin
        addr_hit <= 1'b0;
      end
      if (sck_rise && sel_lvl) begin
        pay_sr <= {dat_lvl, pay_sr[PAY_W-1:1]};
        if (bit_cnt != CNT_SAT[CNT_W-1:0])
          bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign commit     = sel_fall && addr_hit && (bit_cnt == PAY_W[CNT_W-1:0]);
  assign commit_dir = pay_sr[PAY_W-1];
  assign pay_bank   = pay_sr[BANK_W-1:0];
  assign pay_ctl    = pay_sr[CTL_LSB +: CTL_W];

  // Bits between the bank and the control field are fixed filler.
  logic unused_fill;
  assign unused_fill = ^pay_sr[CTL_LSB-1:BANK_W];
endmodule

// File: rtl/lcd_frame_rx_store.sv
module lcd_frame_rx_store
  import lcd_frame_rx_pkg::*;
#(
  parameter int BANK_W = 44
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic                  commit_dir,
  input  logic [BANK_W-1:0]     pay_bank,
  input  ctl_fields_t           pay_ctl,
  output logic [2*BANK_W-1:0]   image,
  output ctl_fields_t           ctl_q,
  output logic                  ctl_empty
);
  localparam int NBANK = 2;

  genvar gb;
  generate
    for (gb = 0; gb < NBANK; gb++) begin : g_bank
      logic [BANK_W-1:0] bank_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bank_q <= '0;
        else if (commit && (commit_dir == gb[0]))
          bank_q <= pay_bank;
      end
      assign image[gb*BANK_W +: BANK_W] = bank_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      ctl_empty <= 1'b1;
    end else if (commit && !commit_dir) begin
      ctl_q     <= pay_ctl;
      ctl_empty <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_frame_rx.sv
module lcd_frame_rx
  import lcd_frame_rx_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] DEV_ADDR = 8'h44,
  parameter int         BANK_W   = 44,
  parameter int         PAY_W    = 56
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_in,
  input  logic                sck_in,
  input  logic                sdi_in,
  output logic [2*BANK_W-1:0] disp_image,
  output logic [2:0]          port_mode,
  output logic                half_bias,
  output logic                seg_blank,
  output logic                pwr_save,
  output logic                ctl_empty
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0]       sync_lvl;
  logic                   commit, commit_dir;
  logic [BANK_W-1:0]      pay_bank;
  logic [CTL_FIELD_W-1:0] pay_ctl;
  ctl_fields_t            ctl_q;

  lcd_frame_rx_sync #(.N(NSYNC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({sdi_in, sck_in, ce_in}),
    .sync_out (sync_lvl)
  );

  lcd_frame_rx_deframe #(
    .ADDR_W   (ADDR_W),
    .DEV_ADDR (DEV_ADDR),
    .PAY_W    (PAY_W),
    .BANK_W   (BANK_W),
    .CTL_W    (CTL_FIELD_W)
  ) u_deframe (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_lvl    (sync_lvl[0]),
    .sck_lvl    (sync_lvl[1]),
    .dat_lvl    (sync_lvl[2]),
    .commit     (commit),
    .commit_dir (commit_dir),
    .pay_bank   (pay_bank),
    .pay_ctl    (pay_ctl)
  );

  lcd_frame_rx_store #(.BANK_W(BANK_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .commit_dir (commit_dir),
    .pay_bank   (pay_bank),
    .pay_ctl    (ctl_fields_t'(pay_ctl)),
    .image      (disp_image),
    .ctl_q      (ctl_q),
    .ctl_empty  (ctl_empty)
  );

  assign port_mode = ctl_q.port_mode;
  assign half_bias = ctl_q.half_bias;
  assign seg_blank = ctl_q.seg_blank;
  assign pwr_save  = ctl_q.pwr_save;
endmodule

// File: rtl/lcd_frame_rx_chk.sv
module lcd_frame_rx_chk #(
  parameter int BANK_W = 44
) (
  input logic                clk,
  input logic                rst_n,
  input logic                commit,
  input logic                commit_dir,
  input logic [2*BANK_W-1:0] disp_image,
  input logic [5:0]          ctl_bits,
  input logic                ctl_empty
);
  assert_lower_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && !commit_dir) |=> $stable(disp_image[BANK_W-1:0]));

  assert_ctl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && !commit_dir) |=> $stable(ctl_bits));

  assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && commit_dir) |=> $stable(disp_image[2*BANK_W-1:BANK_W]));

  assert_empty_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_empty |=> !ctl_empty);

  assert_empty_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_empty && commit && !commit_dir) |=> !ctl_empty);
endmodule

bind lcd_frame_rx lcd_frame_rx_chk #(.BANK_W(BANK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .commit     (commit),
  .commit_dir (commit_dir),
  .disp_image (disp_image),
  .ctl_bits   (ctl_q),
  .ctl_empty  (ctl_empty)
);

// File: tb/tb_lcd_frame_rx.sv
module tb_lcd_frame_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_in = 1'b0, sck_in = 1'b0, sdi_in = 1'b0;
  logic [87:0] disp_image;
  logic [2:0]  port_mode;
  logic        half_bias, seg_blank, pwr_save, ctl_empty;

  int vec_cnt = 0;
  int err_cnt = 0;

  logic [87:0] exp_img = '0;
  logic [5:0]  exp_ctl = '0;
  logic        exp_empty = 1'b1;

  always #2 clk = ~clk;

  lcd_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .ce_in(ce_in), .sck_in(sck_in), .sdi_in(sdi_in),
    .disp_image(disp_image), .port_mode(port_mode), .half_bias(half_bias),
    .seg_blank(seg_blank), .pwr_save(pwr_save), .ctl_empty(ctl_empty)
  );

  function automatic logic [63:0] mk_dir0(logic [43:0] d, logic [5:0] c);
    logic [63:0] v = '0;
    v[43:0]  = d;
    v[54:49] = c;
    v[55]    = 1'b0;
    return v;
  endfunction

  function automatic logic [63:0] mk_dir1(logic [43:0] d);
    logic [63:0] v = '0;
    v[43:0] = d;
    v[55]   = 1'b1;
    return v;
  endfunction

  task automatic check_all(string tag);
    logic [5:0] act_ctl;
    act_ctl = {pwr_save, seg_blank, half_bias, port_mode};
    vec_cnt++;
    if (disp_image !== exp_img || act_ctl !== exp_ctl || ctl_empty !== exp_empty) begin
      err_cnt++;
      $display("FAIL %s: img=%h ctl=%b empty=%b expected img=%h ctl=%b empty=%b",
               tag, disp_image, act_ctl, ctl_empty, exp_img, exp_ctl, exp_empty);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    sck_in = 1'b0;
    sdi_in = b;
    wait_cyc(4);
    sck_in = 1'b1;
    wait_cyc(4);
  endtask

  // Sends one frame, checks R6 before the chip-enable fall, updates the model.
  task automatic send_frame(logic [7:0] addr, logic [63:0] pay, int nbits,
                            logic idle_hi, string tag);
    ce_in  = 1'b0;
    sck_in = idle_hi;
    wait_cyc(4);
    for (int i = 0; i < 8; i++) send_bit(addr[i]);
    if (!idle_hi) begin sck_in = 1'b0; wait_cyc(4); end
    ce_in = 1'b1;
    wait_cyc(4);
    for (int i = 0; i < nbits; i++) send_bit(pay[i]);
    if (!idle_hi) sck_in = 1'b0;
    wait_cyc(6);
    check_all({tag, " R6 pre-commit"});
    ce_in = 1'b0;
    wait_cyc(8);
    if (addr == 8'h44 && nbits == 56) begin
      if (pay[55]) exp_img[87:44] = pay[43:0];
      else begin
        exp_img[43:0] = pay[43:0];
        exp_ctl       = pay[54:49];
        exp_empty     = 1'b0;
      end
    end
    check_all(tag);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240607));
    wait_cyc(3);
    check_all("R1 reset");
    rst_n = 1'b1;
    wait_cyc(4);
    check_all("R1 after release");

    // Direction-1 only: must not clear empty flag (R5, R9)
    send_frame(8'h44, mk_dir1(44'hA5A_5A5A_5A5A), 56, 1'b0, "R5 R9 dir1 first");
    // Direction-0 with filler bits set (R3, R4, R9)
    begin
      logic [63:0] p;
      p = mk_dir0(44'h123_4567_89AB, 6'b101101);
      p[48:44] = 5'b11111;
      send_frame(8'h44, p, 56, 1'b0, "R3 R4 R9 dir0");
    end
    // Wrong address (R2): bit-reversed 0x22
    send_frame(8'h22, mk_dir0(44'hFFF_FFFF_FFFF, 6'b111111), 56, 1'b0, "R2 wrong addr");
    // Counts off by one (R7)
    send_frame(8'h44, mk_dir0(44'h0, 6'b0), 55, 1'b0, "R7 55 bits");
    send_frame(8'h44, mk_dir1(44'h0), 57, 1'b1, "R7 57 bits");
    // Clock idling high (R8)
    send_frame(8'h44, mk_dir0(44'hFED_CBA9_8765, 6'b010010), 56, 1'b1, "R8 idle high dir0");
    send_frame(8'h44, mk_dir1(44'h0F0_F0F0_F0F0), 56, 1'b1, "R8 idle high dir1");

    for (int k = 0; k < 60; k++) begin
      logic [7:0]  a;
      logic [43:0] d;
      logic [5:0]  c;
      int          n;
      logic [63:0] p;
      d = {$urandom, $urandom};
      c = $urandom;
      a = ($urandom % 8 == 0) ? 8'($urandom) : 8'h44;
      case ($urandom % 8)
        0: n = 55;
        1: n = 57;
        default: n = 56;
      endcase
      p = ($urandom % 2 == 1) ? mk_dir1(d) : mk_dir0(d, c);
      if (n == 57) p[56] = $urandom;
      send_frame(a, p, n, 1'($urandom), "R2 R3 R4 R5 R7 R8 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule